// File: doc/BRIEF.md
# Receive Frame Statistics Counters with Threshold Flags

This block keeps four receive frame statistics counters for an Ethernet MAC: all received frames (good or bad), frames with a CRC error, frames with an alignment error, and good unicast frames. Each counter advances by one on a single-cycle strobe from the receive MAC. When a counter reaches the midpoint of its range, or runs past its top value, a sticky flag is set in a raw interrupt status word. Any set flag drives a combined interrupt line.

Software reads the counters and the status word through a simple read port with byte-lane enables. A flag is cleared only by a read of its own counter that includes the lowest byte lane. A control input chooses how a full counter behaves on its next increment: it either wraps to zero or stays at all-ones. In both cases the flag is raised.

Top module: `rx_stat_counters`

## Requirements
- R1: After a synchronous reset, all counters read zero, the status word reads zero, `irq` is low and `rd_data` is zero.
- R2: A high bit of `frame_inc` adds one to its counter on that clock edge (bit 0 = all frames, bit 1 = CRC error, bit 2 = alignment error, bit 3 = good unicast). A counter whose strobe is low keeps its value.
- R3: The increment that takes a counter from one below the midpoint (2^(CNT_W-1)-1) to the midpoint sets that counter's status flag.
- R4: With `stop_at_max` low, an increment of an all-ones counter wraps it to zero and sets its status flag.
- R5: With `stop_at_max` high, an increment of an all-ones counter leaves it at all-ones and sets its status flag.
- R6: The status word reads at offset 0x104. The all-frames flag is bit 0, the CRC flag is bit 5, the alignment flag is bit 6 and the unicast flag is bit 17. Every other bit reads zero.
- R7: The counters read at offsets 0x180, 0x184, 0x188 and 0x18C, in the order of R2, zero-extended to 32 bits. A read returns the value held before the clock edge that samples it, and `rd_data` shows it in the cycle after that edge. An unmapped offset, or a cycle without `rd_en`, gives zero.
- R8: A counter read with `rd_be[0]` high clears that counter's flag. A counter read with `rd_be[0]` low, or a read of the status word, leaves every flag unchanged.
- R9: When a flag-setting increment and a clearing read of the same counter fall on the same edge, the flag ends up set.
- R10: `irq` is high exactly when at least one of the four status flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_inc | input | NUM_CNT | Per-counter increment strobes |
| stop_at_max | input | 1 | 1 = hold a full counter at all-ones, 0 = wrap to zero |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte offset of the register to read |
| rd_be | input | 4 | Byte-lane enables of the read |
| rd_data | output | 32 | Registered read data |
| irq_status | output | 32 | Raw interrupt status word |
| irq | output | 1 | OR of all status flags |

## Verification
A threshold increment and a clearing low-lane read of the same counter can land on the same edge. Only one of them can decide the flag. The bench provokes this in two ways. First, it parks the alignment-error counter one below its midpoint and issues the read together with the crossing strobe. Second, it repeats the pair at the top of the range. The reference model expects the flag set after both. The bench then pairs a non-threshold increment with the same read and expects the flag clear, so that both resolutions of the conflict are exercised.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int unsigned NUM_CNT = 4;
  // status bit index of each counter's flag
  localparam int unsigned FLAG_BIT [NUM_CNT] = '{0, 5, 6, 17};
  localparam logic [11:0] STATUS_OFS = 12'h104;
  localparam logic [11:0] CNT_BASE   = 12'h180;
endpackage

// File: rtl/rx_stat_cnt.sv
module rx_stat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             stop_at_max,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] HALF_M1  = {1'b0, {(CNT_W-1){1'b1}}};

  logic at_max, at_half_m1, thresh_evt;

  assign at_max     = (cnt_q == ALL_ONES);
  assign at_half_m1 = (cnt_q == HALF_M1);
  assign thresh_evt = inc && (at_max || at_half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (at_max && stop_at_max) cnt_q <= ALL_ONES;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (thresh_evt) flag_q <= 1'b1;
    else if (clr_req)    flag_q <= 1'b0;
  end

  // R2
  hold_no_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt_q));
  // R3
  half_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q == HALF_M1) |=> (flag_q && cnt_q == {1'b1, {(CNT_W-1){1'b0}}}));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q == ALL_ONES && !stop_at_max) |=> (cnt_q == '0 && flag_q));
  // R5
  stop_max_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q == ALL_ONES && stop_at_max) |=> (cnt_q == ALL_ONES && flag_q));
  // R8
  clear_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(inc && (cnt_q == ALL_ONES || cnt_q == HALF_M1))) |=> !flag_q);
endmodule

// File: rtl/rx_stat_rdport.sv
module rx_stat_rdport
  import rx_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [3:0]               rd_be,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input  logic [31:0]              status,
  output logic [NUM_CNT-1:0]       clr_req,
  output logic [31:0]              rd_data
);
  logic [NUM_CNT-1:0] hit;
  logic [31:0]        sel;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign hit[i]     = rd_en && (rd_addr == ADDR_W'(CNT_BASE + 12'(4*i)));
    assign clr_req[i] = hit[i] && rd_be[0];
  end

  always_comb begin
    sel = '0;
    if (rd_addr == ADDR_W'(STATUS_OFS)) sel = status;
    for (int i = 0; i < NUM_CNT; i++)
      if (hit[i]) sel = 32'(cnt_flat[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
    else            rd_data <= '0;
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
  import rx_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] frame_inc,
  input  logic               stop_at_max,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [3:0]         rd_be,
  output logic [31:0]        rd_data,
  output logic [31:0]        irq_status,
  output logic               irq
);
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       flag;
  logic [NUM_CNT-1:0]       clr_req;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    rx_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc        (frame_inc[i]),
      .stop_at_max(stop_at_max),
      .clr_req    (clr_req[i]),
      .cnt_q      (cnt_flat[i*CNT_W +: CNT_W]),
      .flag_q     (flag[i])
    );
  end

  always_comb begin
    irq_status = '0;
    for (int i = 0; i < NUM_CNT; i++) irq_status[FLAG_BIT[i]] = flag[i];
  end

  assign irq = |flag;

  rx_stat_rdport #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_be   (rd_be),
    .cnt_flat(cnt_flat),
    .status  (irq_status),
    .clr_req (clr_req),
    .rd_data (rd_data)
  );

  // R10
  irq_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_status != '0));
endmodule

// File: tb/test_rx_stat_counters.sv
module test_rx_stat_counters;
  localparam int CW = 8;
  localparam int MAXV = (1 << CW) - 1;
  localparam int HALF = 1 << (CW - 1);

  logic        clk = 0;
  logic        rst;
  logic [3:0]  frame_inc;
  logic        stop_at_max;
  logic        rd_en;
  logic [11:0] rd_addr;
  logic [3:0]  rd_be;
  logic [31:0] rd_data, irq_status;
  logic        irq;

  int tests = 0, fails = 0, cycles = 0;
  int m_cnt [4];
  bit m_flag [4];
  int m_rd;
  string req = "R1";
  int bitpos [4] = '{0, 5, 6, 17};

  always #2 clk = ~clk;

  rx_stat_counters #(.CNT_W(CW), .ADDR_W(12)) i_rx_stat_counters (
    .clk(clk), .rst(rst), .frame_inc(frame_inc), .stop_at_max(stop_at_max),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_be(rd_be),
    .rd_data(rd_data), .irq_status(irq_status), .irq(irq));

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    for (int i = 0; i < 4; i++) s[bitpos[i]] = m_flag[i];
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic [3:0] inc, logic rd, logic [11:0] addr, logic [3:0] be);
    logic [31:0] st;
    frame_inc = inc; rd_en = rd; rd_addr = addr; rd_be = be;
    @(posedge clk);
    st = m_status();
    m_rd = 0;
    if (rd) begin
      if (addr == 12'h104) m_rd = st;
      for (int i = 0; i < 4; i++) if (addr == 12'h180 + 12'(4*i)) m_rd = m_cnt[i];
    end
    for (int i = 0; i < 4; i++) begin
      bit ev = inc[i] && (m_cnt[i] == HALF - 1 || m_cnt[i] == MAXV);
      bit cl = rd && addr == 12'h180 + 12'(4*i) && be[0];
      if (ev) m_flag[i] = 1; else if (cl) m_flag[i] = 0;
      if (inc[i]) m_cnt[i] = (m_cnt[i] == MAXV) ? (stop_at_max ? MAXV : 0) : m_cnt[i] + 1;
    end
    @(negedge clk);
    check({req, " rd_data"}, rd_data, 32'(m_rd));
    check({req, " status"}, irq_status, m_status());
    check({req, " irq"}, {31'b0, irq}, {31'b0, m_status() != 0});
  endtask

  task automatic idle(); cyc(4'b0, 0, 12'h0, 4'h0); endtask
  task automatic rdc(int i, logic [3:0] be); cyc(4'b0, 1, 12'h180 + 12'(4*i), be); endtask
  task automatic bump(int i, int n);
    for (int k = 0; k < n; k++) cyc(4'(1 << i), 0, 12'h0, 4'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; frame_inc = 0; stop_at_max = 0; rd_en = 0; rd_addr = 0; rd_be = 0;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_flag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    req = "R1";
    check("R1 rd_data", rd_data, 0);
    check("R1 status", irq_status, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int i = 0; i < 4; i++) rdc(i, 4'hF);
    // R2 mixed strobe patterns, R7 reads
    req = "R2";
    cyc(4'b1111, 0, 0, 0); cyc(4'b0101, 0, 0, 0); cyc(4'b1000, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0); cyc(4'b0110, 1, 12'h184, 4'hF);
    req = "R7";
    for (int i = 0; i < 4; i++) rdc(i, 4'hF);
    cyc(4'b0000, 1, 12'h000, 4'hF); cyc(4'b0000, 1, 12'h190, 4'hF);
    cyc(4'b0001, 1, 12'h180, 4'hF);
    // R3 midpoint on all-frames counter
    req = "R3";
    bump(0, HALF - m_cnt[0]);
    // R6 status word read and bit positions
    req = "R6";
    cyc(4'b0, 1, 12'h104, 4'hF);
    // R8 read without low lane keeps flag, status read keeps flag
    req = "R8";
    rdc(0, 4'b1110); cyc(4'b0, 1, 12'h104, 4'h1); rdc(0, 4'b0001); idle();
    // R4 wrap on all-frames counter
    req = "R4";
    bump(0, MAXV - m_cnt[0]); rdc(0, 4'h1);
    bump(0, 2); rdc(0, 4'hF); rdc(0, 4'hF);
    // R5 stop at max on CRC counter
    req = "R5";
    stop_at_max = 1;
    bump(1, MAXV - m_cnt[1]); rdc(1, 4'h1);
    bump(1, 3); rdc(1, 4'h1); rdc(1, 4'h1);
    // R10 several flags at once
    req = "R10";
    bump(3, HALF - m_cnt[3]);
    bump(1, 1); cyc(4'b0, 1, 12'h104, 4'hF);
    rdc(3, 4'h1); rdc(1, 4'h1);
    // R9 set and clear on the same edge
    req = "R9";
    stop_at_max = 0;
    bump(2, HALF - 1 - m_cnt[2]);
    cyc(4'b0100, 1, 12'h188, 4'h1);
    cyc(4'b0100, 1, 12'h188, 4'h1);
    bump(2, MAXV - m_cnt[2]);
    rdc(2, 4'h1);
    cyc(4'b0100, 1, 12'h188, 4'h1);
    cyc(4'b0100, 1, 12'h188, 4'h1);
    idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule